// File: doc/BRIEF.md
# Inter-Processor and Message Doorbell Unit

This block keeps a 32-bit pending-doorbell register and a 32-bit enable register for each of up to four processors. One shared trigger register lets any processor ring one chosen doorbell bit in any chosen set of processors with a single write. The trigger word carries a processor bitmap in bits 8 and up and a doorbell number in bits 4:0. A PCIe message-signalled interrupt that has already been routed to the trigger address arrives on a separate valid/ready input. Its data word is decoded exactly like a register write to the trigger. A payload of 0xF00 | (16 + k) therefore rings doorbell 16 + k on all four processors.

Pending bits fall into two groups. Doorbells 0 to 7 are inter-processor messages and doorbells 16 to 31 are message interrupts. Each processor gets one registered summary line per group, raised while any enabled bit of that group is pending. Software acknowledges pending bits by writing the pending register. Each zero in the written word clears the matching bit, and each one leaves its bit alone.

The register port is a plain single-cycle write strobe with a combinational read. The message input obeys valid/ready rules. Once `msg_valid` is raised, the sender keeps it high and keeps `msg_data` stable until it sees `msg_ready` high at a clock edge. The unit lowers `msg_ready` only in a cycle where the register port writes the trigger register. In that case the message is taken in the next cycle without that collision.

Top module: `db_doorbell_unit`

## Requirements
- R1: After reset every pending register and every enable register reads 0, and all summary outputs are low.
- R2: A register write to offset 0x4 with word W sets pending bit W[4:0] in every processor p for which W[8+p] is 1, and changes no other pending bit.
- R3: A message accepted on the input (msg_valid and msg_ready both high at an edge) is decoded like R2. Data 0xF00 | (16+k) sets pending bit 16+k in all four processors.
- R4: msg_ready is low in a cycle where reg_wr is high with reg_addr 0x4 and high in every other cycle. A message that is not accepted changes no pending bit.
- R5: A register write to offset 0x8 changes only the pending register of the processor selected by reg_cpu. It clears each bit whose written value is 0 and keeps each bit whose written value is 1, so writing 0 clears every pending bit.
- R6: If a bit is both set by a trigger or message and cleared by a pending-register write in the same cycle, the bit ends up set.
- R7: A register write to offset 0x8+4 (0xC) loads the selected processor's enable register from bits 7:0 and 31:16 of the word. Enable bits 15:8 always read as 0.
- R8: ipi_irq[p] equals, one cycle after the pending or enable state changes, the OR of pending[7:0] AND enable[7:0] of processor p.
- R9: msg_irq[p] equals, one cycle after the state changes, the OR of pending[31:16] AND enable[31:16] of processor p.
- R10: Doorbell numbers 8 to 15 set their pending bits, which read back, but those bits affect neither summary.
- R11: reg_rdata shows the selected processor's pending register at offset 0x8 and its enable register at 0xC, and reads 0 at any other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_cpu | input | 2 | Processor whose bank is accessed at 0x8 and 0xC |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| msg_valid | input | 1 | Message doorbell write valid |
| msg_ready | output | 1 | Message doorbell write accepted |
| msg_data | input | 32 | Message payload, decoded like a trigger word |
| ipi_irq | output | 4 | Per-processor summary of doorbells 0 to 7 |
| msg_irq | output | 4 | Per-processor summary of doorbells 16 to 31 |

## Verification
The hardest case to reach is a set and a clear of the same pending bit in one cycle. It needs an incoming message that lands in the same cycle as a pending-register write that zeroes that bit. The collision with a trigger write also has to be avoided, or the message would stall. The bench produces this case directly by driving a message and a zero write to the pending register in one cycle. Random operations also mix message traffic with register writes, so overlaps of clears, sets, message stalls and doorbell numbers 8 to 15 come up many times.

// File: rtl/db_pkg.sv
package db_pkg;

  // Register offsets: the trigger, pending and enable locations are fixed
  localparam logic [3:0] OFF_TRIG    = 4'h4;
  localparam logic [3:0] OFF_PENDING = 4'h8;
  localparam logic [3:0] OFF_ENABLE  = 4'hC;

  // Processor bitmap starts at this bit of a trigger word
  localparam int MAP_LSB = 8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_TRIG,
    SEL_PENDING,
    SEL_ENABLE
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [3:0] off);
    reg_sel_e s;
    case (off)
      OFF_TRIG:    s = SEL_TRIG;
      OFF_PENDING: s = SEL_PENDING;
      OFF_ENABLE:  s = SEL_ENABLE;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction

  // Mask with ones from bit lo to bit hi inclusive
  function automatic logic [31:0] span_mask(input int lo, input int hi);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 32; b++) begin
      if (b >= lo && b <= hi) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/db_trig_decode.sv
module db_trig_decode #(
  parameter int NUM_CPU = 4,
  parameter int DB_W    = 32,
  localparam int NUM_W  = $clog2(DB_W)
) (
  input  logic                             fire_i,
  input  logic [DB_W-1:0]                  word_i,
  output logic [NUM_CPU-1:0][DB_W-1:0]     set_o
);
  import db_pkg::*;

  logic [DB_W-1:0] onehot;

  assign onehot = DB_W'(1) << word_i[NUM_W-1:0];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_target
    assign set_o[c] = (fire_i && word_i[MAP_LSB+c]) ? onehot : '0;
  end

endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank #(
  parameter int DB_W   = 32,
  parameter int IPI_LO = 0,
  parameter int IPI_HI = 7,
  parameter int MSG_LO = 16,
  parameter int MSG_HI = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DB_W-1:0] set_i,
  input  logic            clr_wr_i,
  input  logic            en_wr_i,
  input  logic [DB_W-1:0] wdata_i,
  output logic [DB_W-1:0] pending_o,
  output logic [DB_W-1:0] enable_o,
  output logic            ipi_o,
  output logic            msg_o
);
  import db_pkg::*;

  localparam logic [DB_W-1:0] IPI_M  = DB_W'(span_mask(IPI_LO, IPI_HI));
  localparam logic [DB_W-1:0] MSG_M  = DB_W'(span_mask(MSG_LO, MSG_HI));
  localparam logic [DB_W-1:0] EN_IMP = IPI_M | MSG_M;

  logic [DB_W-1:0] pend_q, pend_d;
  logic [DB_W-1:0] en_q;
  logic            ipi_q, msg_q;
  logic [DB_W-1:0] live;

  // Clear first, then OR in the sets: a set always survives
  always_comb begin
    pend_d = pend_q;
    if (clr_wr_i) pend_d = pend_d & wdata_i;
    pend_d = pend_d | set_i;
  end

  assign live = pend_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      ipi_q  <= 1'b0;
      msg_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (en_wr_i) en_q <= wdata_i & EN_IMP;
      ipi_q  <= |(live & IPI_M);
      msg_q  <= |(live & MSG_M);
    end
  end

  assign pending_o = pend_q;
  assign enable_o  = en_q;
  assign ipi_o     = ipi_q;
  assign msg_o     = msg_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R6

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr_i && set_i == '0) |=> $stable(pend_q)); // R2

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i |=> $stable(en_q)); // R7

  AST_IPI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ipi_q) |-> $past(|(pend_q & IPI_M))); // R8

  AST_MSG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_q) |-> $past(|(pend_q & MSG_M))); // R9

endmodule

// File: rtl/db_doorbell_unit.sv
module db_doorbell_unit #(
  parameter int NUM_CPU = 4,
  parameter int DB_W    = 32,
  parameter int IPI_LO  = 0,
  parameter int IPI_HI  = 7,
  parameter int MSG_LO  = 16,
  parameter int MSG_HI  = 31,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [3:0]         reg_addr,
  input  logic [CPU_W-1:0]   reg_cpu,
  input  logic [DB_W-1:0]    reg_wdata,
  output logic [DB_W-1:0]    reg_rdata,
  input  logic               msg_valid,
  output logic               msg_ready,
  input  logic [DB_W-1:0]    msg_data,
  output logic [NUM_CPU-1:0] ipi_irq,
  output logic [NUM_CPU-1:0] msg_irq
);
  import db_pkg::*;

  reg_sel_e sel;
  logic     trig_wr, msg_fire;

  logic [NUM_CPU-1:0][DB_W-1:0] set_reg, set_msg, set_all;
  logic [NUM_CPU-1:0][DB_W-1:0] pend_all, en_all;

  assign sel      = decode_offset(reg_addr);
  assign trig_wr  = reg_wr && (sel == SEL_TRIG);
  // Register trigger has the decoder this cycle; a message waits
  assign msg_ready = !trig_wr;
  assign msg_fire  = msg_valid && msg_ready;

  db_trig_decode #(.NUM_CPU(NUM_CPU), .DB_W(DB_W)) u_dec_reg (
    .fire_i (trig_wr),
    .word_i (reg_wdata),
    .set_o  (set_reg)
  );

  db_trig_decode #(.NUM_CPU(NUM_CPU), .DB_W(DB_W)) u_dec_msg (
    .fire_i (msg_fire),
    .word_i (msg_data),
    .set_o  (set_msg)
  );

  assign set_all = set_reg | set_msg;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    logic here;
    assign here = (reg_cpu == CPU_W'(c));

    db_cpu_bank #(
      .DB_W(DB_W), .IPI_LO(IPI_LO), .IPI_HI(IPI_HI),
      .MSG_LO(MSG_LO), .MSG_HI(MSG_HI)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_all[c]),
      .clr_wr_i  (reg_wr && here && (sel == SEL_PENDING)),
      .en_wr_i   (reg_wr && here && (sel == SEL_ENABLE)),
      .wdata_i   (reg_wdata),
      .pending_o (pend_all[c]),
      .enable_o  (en_all[c]),
      .ipi_o     (ipi_irq[c]),
      .msg_o     (msg_irq[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (reg_cpu == CPU_W'(c)) begin
        if (sel == SEL_PENDING) reg_rdata = pend_all[c];
        else if (sel == SEL_ENABLE) reg_rdata = en_all[c];
      end
    end
  end

  AST_MSG_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready && !reg_wr) |-> 1'b0); // R4

endmodule

// File: tb/tb_db_doorbell_unit.sv
`timescale 1ns/1ps
module tb_db_doorbell_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [1:0]  reg_cpu = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic [31:0] msg_data = '0;
  logic [3:0]  ipi_irq, msg_irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_pend [4];
  logic [31:0] m_en   [4];

  always #5 clk = ~clk;

  db_doorbell_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_cpu(reg_cpu), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
    .ipi_irq(ipi_irq), .msg_irq(msg_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] trig_set(input logic [31:0] w, input int c);
    return w[8+c] ? (32'd1 << w[4:0]) : 32'd0;
  endfunction

  // One clock of stimulus; model updated at the edge
  task automatic op(input logic wr, input logic [3:0] a, input logic [1:0] c,
                    input logic [31:0] d, input logic mv, input logic [31:0] md);
    logic rdy;
    reg_wr = wr; reg_addr = a; reg_cpu = c; reg_wdata = d;
    msg_valid = mv; msg_data = md;
    #1;
    rdy = !(wr && a == 4'h4);
    chk("R4 msg_ready", {31'd0, msg_ready}, {31'd0, rdy});
    @(posedge clk);
    for (int p = 0; p < 4; p++) begin
      logic [31:0] s;
      s = 32'd0;
      if (wr && a == 4'h4) s |= trig_set(d, p);
      if (mv && rdy) s |= trig_set(md, p);
      if (wr && a == 4'h8 && c == 2'(p)) m_pend[p] &= d;
      m_pend[p] |= s;
      if (wr && a == 4'hC && c == 2'(p)) m_en[p] = d & 32'hFFFF_00FF;
    end
    @(negedge clk);
    reg_wr = 1'b0; msg_valid = 1'b0;
  endtask

  // Idle one cycle so summaries settle, then compare all banks
  task automatic check_all(input string tag);
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      reg_cpu = 2'(p);
      reg_addr = 4'h8; #1;
      chk({tag, " R11 pending"}, reg_rdata, m_pend[p]);
      reg_addr = 4'hC; #1;
      chk({tag, " R7 enable"}, reg_rdata, m_en[p]);
      chk({tag, " R8 ipi_irq"}, {31'd0, ipi_irq[p]},
          {31'd0, |(m_pend[p] & m_en[p] & 32'h0000_00FF)});
      chk({tag, " R9 msg_irq"}, {31'd0, msg_irq[p]},
          {31'd0, |(m_pend[p] & m_en[p] & 32'hFFFF_0000)});
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    for (int p = 0; p < 4; p++) begin m_pend[p] = '0; m_en[p] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 ipi_irq", {28'd0, ipi_irq}, 32'd0);
    chk("R1 msg_irq", {28'd0, msg_irq}, 32'd0);
    check_all("R1");

    // R7 enable everything; 15:8 read zero
    for (int p = 0; p < 4; p++) op(1, 4'hC, 2'(p), 32'hFFFF_FFFF, 0, 0);
    check_all("R7");

    // R2 ring doorbell 3 on processors 0 and 2
    op(1, 4'h4, 0, (32'h5 << 8) | 32'd3, 0, 0);
    check_all("R2");

    // R3 message vector 5 -> bit 21 everywhere
    op(0, 0, 0, 0, 1, 32'hF00 | 32'd21);
    check_all("R3");

    // R10 doorbell 10 on processor 1: readable, no summary
    op(1, 4'h8, 1, 32'd0, 0, 0);
    op(1, 4'hC, 1, 32'hFFFF_FFFF, 0, 0);
    op(1, 4'h4, 0, (32'h2 << 8) | 32'd10, 0, 0);
    check_all("R10");
    chk("R10 ipi cpu1", {31'd0, ipi_irq[1]}, 32'd0);
    chk("R10 msg cpu1", {31'd0, msg_irq[1]}, 32'd0);

    // R5 clear only bit 3 on processor 0
    op(1, 4'h8, 0, 32'hFFFF_FFF7, 0, 0);
    check_all("R5");

    // R6 zero write to processor 2 while message sets bit 21
    op(1, 4'h8, 2, 32'd0, 1, 32'hF00 | 32'd21);
    check_all("R6");
    reg_addr = 4'h8; reg_cpu = 2; #1;
    chk("R6 bit21 kept", reg_rdata, 32'h0020_0000);

    // R4 trigger write stalls a message, which is taken next cycle
    op(1, 4'h4, 0, (32'h8 << 8) | 32'd1, 1, 32'hF00 | 32'd30);
    check_all("R4 stalled");
    op(0, 0, 0, 0, 1, 32'hF00 | 32'd30);
    check_all("R4 taken");

    // R11 other offsets read zero
    reg_addr = 4'h0; reg_cpu = 0; #1;
    chk("R11 offset0", reg_rdata, 32'd0);
    reg_addr = 4'h4; #1;
    chk("R11 offset4", reg_rdata, 32'd0);

    // R5 zero write clears everything
    for (int p = 0; p < 4; p++) op(1, 4'h8, 2'(p), 32'd0, 0, 0);
    check_all("R5 all");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  a;
      logic [31:0] d, md;
      logic        wr, mv;
      case ($urandom % 4)
        0: a = 4'h4;
        1: a = 4'h8;
        2: a = 4'hC;
        default: a = 4'h0;
      endcase
      wr = ($urandom % 4) != 0;
      mv = ($urandom % 3) == 0;
      d  = $urandom;
      if (a == 4'h8 && ($urandom % 2)) d = d | $urandom;
      md = ($urandom % 2) ? (32'hF00 | (32'd16 + ($urandom % 16))) : $urandom;
      op(wr, a, 2'($urandom % 4), d, mv, md);
      if (i % 4 == 3) check_all("rand R2 R3 R5");
    end
    check_all("final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule